// File: doc/BRIEF.md
# Dual-Lane Double to Int32 Truncating Converter

This block takes a 128-bit vector that holds two IEEE-754 double-precision values. It turns each value into a signed 32-bit integer. The fraction is always dropped, so the result is rounded toward zero. A value that does not fit saturates to the nearest 32-bit limit. Each lane's 32-bit result is written twice, into both 32-bit words of that lane's half of the 128-bit output.

Alongside the data, the block reports three status flags for each operation: invalid conversion, signaling NaN and inexact. Each flag is the OR of the two lanes. A trap request is raised when the inexact-trap enable is set and the result is inexact.

The conversion logic is combinational and is followed by one register stage. Every operation is qualified by a valid pulse.

Top module: `dcvt_i32x2`

## Requirements
- R1: Lane i (i = 0, 1) is read from `src[64*i+63:64*i]`. Its 32-bit result appears in both `res[64*i+31:64*i]` and `res[64*i+63:64*i+32]`, and each lane is converted independently.
- R2: An input whose magnitude is at least 1 and which lies in range is converted to its integer part, truncated toward zero, in two's complement. The inexact flag is raised only if fraction bits were dropped. Values 2^31-1 and -2^31 convert exactly, with no flag.
- R3: A NaN (exponent all ones, fraction nonzero) produces 0x80000000 and sets `flag_invalid`. When the fraction MSB (bit 51) is 0, the NaN is signaling, and `flag_snan` is also set.
- R4: An input >= 2^31 or +infinity produces 0x7FFFFFFF. An input <= -2^31-1 or -infinity produces 0x80000000. In each of these cases `flag_invalid` is set and the lane does not raise inexact.
- R5: An input strictly between 2^31-1 and 2^31 produces 0x7FFFFFFF with inexact. An input strictly between -2^31-1 and -2^31 produces 0x80000000 with inexact. Neither case sets invalid.
- R6: Zero, negative zero, subnormals and any value with magnitude below 1 produce 0. Every nonzero one of these sets inexact.
- R7: Each output flag is the OR of the two lanes' flags.
- R8: `trap_req` equals `trap_en_inexact AND` the operation's inexact flag, registered with the result.
- R9: Outputs appear one cycle after `in_valid`, with `out_valid` high. While `out_valid` is low, all flags and `trap_req` are 0.
- R10: A synchronous active-high `rst` clears `res`, `out_valid`, all flags and `trap_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| src | input | 128 | Two double-precision lanes |
| trap_en_inexact | input | 1 | Enable trap on inexact result |
| out_valid | output | 1 | Result valid, one cycle after request |
| res | output | 128 | Two duplicated int32 results |
| flag_invalid | output | 1 | Invalid conversion (NaN, infinity or out of range) |
| flag_snan | output | 1 | A lane held a signaling NaN |
| flag_inexact | output | 1 | A lane lost fraction bits or was rounded to a limit |
| trap_req | output | 1 | Inexact trap request |

## Verification
The block holds no state beyond its output register, so a wrong decode shows up at the ports in the very next cycle after the request. It appears as a wrong word, as mismatched duplicate words, or as a flag set on the wrong path.

The riskiest spots are the edges of the exponent classes and the sign-dependent window just below -2^31. A wrong shift bound or a wrong compare against the 2^21 fraction threshold changes the saturation value or moves a flag between invalid and inexact. The bench therefore aims directed values at each boundary and mixes in random values with exponents near the 2^31 range.

// File: rtl/dcvt_i32x2.sv
module dcvt_i32x2 #(
  parameter int LANES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [64*LANES-1:0]  src,
  input  logic                 trap_en_inexact,
  output logic                 out_valid,
  output logic [64*LANES-1:0]  res,
  output logic                 flag_invalid,
  output logic                 flag_snan,
  output logic                 flag_inexact,
  output logic                 trap_req
);

  localparam int          W      = 32;
  localparam logic [10:0] BIAS   = 11'd1023;
  localparam logic [10:0] E_TOP  = BIAS + 11'd31;
  localparam logic [W-1:0] I_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] I_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]     lane_val [LANES];
  logic [LANES-1:0] l_inv, l_snan, l_inx;
  logic [64*LANES-1:0] res_d;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic        sgn;
    logic [10:0] ex;
    logic [51:0] fr;
    assign sgn = src[64*i+63];
    assign ex  = src[64*i+52 +: 11];
    assign fr  = src[64*i +: 52];

    always_comb begin
      logic [52:0] mant;
      logic [10:0] ub;
      logic [5:0]  sh;
      logic [W-1:0] mag;
      mant = {1'b1, fr};
      ub   = ex - BIAS;
      sh   = 6'd52 - ub[5:0];
      mag  = W'(mant >> sh);
      lane_val[i] = '0;
      l_inv[i]  = 1'b0;
      l_snan[i] = 1'b0;
      l_inx[i]  = 1'b0;
      if (ex == 11'h7FF) begin
        l_inv[i] = 1'b1;
        if (fr != '0) begin
          lane_val[i] = I_MIN;
          l_snan[i]   = ~fr[51];
        end else begin
          lane_val[i] = sgn ? I_MIN : I_MAX;
        end
      end else if (ex < BIAS) begin
        l_inx[i] = (ex != '0) || (fr != '0);
      end else if (ex >= E_TOP) begin
        if (sgn && ex == E_TOP && fr[51:21] == '0) begin
          lane_val[i] = I_MIN;
          l_inx[i]    = (fr[20:0] != '0);
        end else begin
          lane_val[i] = sgn ? I_MIN : I_MAX;
          l_inv[i]    = 1'b1;
        end
      end else begin
        lane_val[i] = sgn ? -mag : mag;
        l_inx[i]    = |(mant & ~({53{1'b1}} << sh));
      end
    end

    assign res_d[64*i +: 64] = {lane_val[i], lane_val[i]};

    assert_lane_excl_R4: assert property (@(posedge clk) disable iff (rst)
      !(l_inv[i] && l_inx[i]));
    assert_snan_inv_R3: assert property (@(posedge clk) disable iff (rst)
      l_snan[i] |-> l_inv[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      res          <= '0;
      flag_invalid <= 1'b0;
      flag_snan    <= 1'b0;
      flag_inexact <= 1'b0;
      trap_req     <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      flag_invalid <= in_valid & (|l_inv);
      flag_snan    <= in_valid & (|l_snan);
      flag_inexact <= in_valid & (|l_inx);
      trap_req     <= in_valid & trap_en_inexact & (|l_inx);
      if (in_valid) res <= res_d;
    end
  end

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid));
  assert_idle_flags_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(flag_invalid || flag_snan || flag_inexact || trap_req));
  assert_trap_R8: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> flag_inexact);
  assert_dup_words_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (res[31:0] == res[63:32] && res[95:64] == res[127:96]));

endmodule

// File: tb/dcvt_i32x2_tb.sv
module dcvt_i32x2_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, in_valid = 0, trap_en_inexact = 0;
  logic [127:0] src = '0;
  logic out_valid, flag_invalid, flag_snan, flag_inexact, trap_req;
  logic [127:0] res;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcvt_i32x2 u_dut (.clk(clk), .rst(rst), .in_valid(in_valid), .src(src),
    .trap_en_inexact(trap_en_inexact), .out_valid(out_valid), .res(res),
    .flag_invalid(flag_invalid), .flag_snan(flag_snan),
    .flag_inexact(flag_inexact), .trap_req(trap_req));

  // returns {invalid, snan, inexact, value}
  function automatic logic [34:0] ref_cvt(input logic [63:0] b);
    real x;
    int r;
    if (b[62:52] == 11'h7FF) begin
      if (b[51:0] != 0) return {1'b1, ~b[51], 1'b0, 32'h80000000};
      return {3'b100, b[63] ? 32'h80000000 : 32'h7FFFFFFF};
    end
    x = $bitstoreal(b);
    if (x >= 2147483648.0) return {3'b100, 32'h7FFFFFFF};
    if (x <= -2147483649.0) return {3'b100, 32'h80000000};
    if (x < -2147483648.0) return {3'b001, 32'h80000000};
    r = $rtoi(x);
    return {2'b00, ($itor(r) != x), r};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] a, input logic [63:0] b, input logic te, input string tag);
    logic [34:0] e0, e1;
    e0 = ref_cvt(a);
    e1 = ref_cvt(b);
    @(negedge clk);
    src = {b, a}; in_valid = 1; trap_en_inexact = te;
    @(negedge clk);
    in_valid = 0;
    chk({tag, " R1/R2..R6 data"}, res, {e1[31:0], e1[31:0], e0[31:0], e0[31:0]});
    chk({tag, " R7 flags"}, {124'd0, out_valid, flag_invalid, flag_snan, flag_inexact},
        {124'd0, 1'b1, e0[34] | e1[34], e0[33] | e1[33], e0[32] | e1[32]});
    chk({tag, " R8 trap"}, {127'd0, trap_req}, {127'd0, te & (e0[32] | e1[32])});
  endtask

  function automatic logic [63:0] rnd_dbl();
    logic [63:0] v;
    v = {$urandom, $urandom};
    case ($urandom % 8)
      0, 1, 2, 3: v[62:52] = 11'd1010 + 11'($urandom % 48);
      4: v[62:52] = 11'd1053 + 11'($urandom % 3);
      5: v[62:52] = 11'($urandom % 2) * 11'h7FF;
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk);
    chk("R10 reset", {res, 123'd0, out_valid, flag_invalid, flag_snan, flag_inexact, trap_req}, '0);
    rst = 0;
    run(64'h0000000000000000, 64'h8000000000000000, 1, "R6 zeros");
    run(64'h3FF8000000000000, 64'hBFF8000000000000, 1, "R2 +-1.5");
    run(64'h41DFFFFFFFC00000, 64'hC1E0000000000000, 1, "R2 exact limits");
    run(64'h41DFFFFFFFE00000, 64'h4046000000000000, 0, "R5 max-0.5 te0");
    run(64'h41E0000000000000, 64'hC1E0000000200000, 1, "R4 2^31 / -2^31-1");
    run(64'hC1E0000000100000, 64'h4000000000000000, 1, "R5 -2^31-0.5");
    run(64'h7FF0000000000000, 64'hFFF0000000000000, 1, "R4 infinities");
    run(64'h7FF8000000000000, 64'h3FF0000000000000, 1, "R3 qnan");
    run(64'h7FF0000000000001, 64'h3FE0000000000000, 1, "R3 snan with R7 inexact lane");
    run(64'h0000000000000001, 64'hBFE0000000000000, 1, "R6 subnormal/-0.5");
    run(64'h41E0000000000000, 64'h3FF4000000000000, 1, "R7 invalid+inexact lanes");
    @(negedge clk);
    chk("R9 idle flags", {124'd0, out_valid, flag_invalid, flag_inexact, trap_req}, '0);
    for (int k = 0; k < 400; k++) run(rnd_dbl(), rnd_dbl(), 1'($urandom), "random");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule